// File: doc/BRIEF.md
# Watchdog Timer with Run/Halt-Aware Reset

This block is the watchdog of a small microcontroller. It counts one of two clock sources, fixed at build time: either ticks from a dedicated slow oscillator, or the instruction clock (the system clock divided by four). Every advance first goes through a 256-step divider and then through a 7-bit prescaler. A 3-bit ratio field in a configuration register chooses the prescaler tap. If software stops clearing the count, the block raises a timeout.

The response to a timeout depends on the power state. While the CPU is running, the timeout asks for a full chip reset, and the ratio field goes back to its maximum. While the CPU is halted, the timeout asks for a warm reset that only zeroes PC and SP and wakes the core; the ratio field keeps its value. The block also owns the two reset-cause flags, the time-out flag and the power-down flag. Software can read these flags but cannot write them.

The timeout appears as a single-cycle pulse on `expire`. A qualifier, `expire_warm`, travels with it and tells the reset controller which kind of reset to apply. A build option can disable the watchdog entirely.

Top module: `watchdog_guard`

## Requirements
- R1: After the power-up reset `rst`, `cfg_rdata` reads 0x07, `to_flag` and `pd_flag` are 0, and `expire` is 0.
- R2: With the oscillator source, every rising edge of `osc_tick` advances the count by exactly one. A timeout occurs on exactly the (256 × 2^WS)-th tick after the last clear, where WS is `cfg_rdata[2:0]`.
- R3: With the instruction-clock source, the count advances once every 4 clock cycles. With WS = 0, the timeout comes between 1000 and 1040 cycles after a clear.
- R4: A write through `cfg_we` stores only bits 2..0 of `cfg_wdata`. Bits 7..3 of `cfg_rdata` always read 0.
- R5: Each of the following restarts the whole count from zero: a `clr_cmd` pulse, a rising edge on `halt_mode`, or `ext_rst`.
- R6: `expire` is high for exactly one cycle per timeout. `expire_warm` is high in that same cycle exactly when `halt_mode` was high.
- R7: A timeout while running sets `to_flag`, leaves `pd_flag` unchanged and returns `cfg_rdata` to 0x07.
- R8: A timeout while halted sets both `to_flag` and `pd_flag` and leaves `cfg_rdata` unchanged.
- R9: A rising edge on `halt_mode` sets `pd_flag` and clears `to_flag`. A `clr_cmd` pulse clears both flags.
- R10: `ext_rst` returns `cfg_rdata` to 0x07 and leaves both flags unchanged. A configuration write never changes either flag.
- R11: When the watchdog is disabled by build option, `expire` never rises and `clr_cmd` has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| ext_rst | input | 1 | External reset pin request, synchronous, active high |
| osc_tick | input | 1 | Tick from the dedicated watchdog oscillator (asynchronous) |
| halt_mode | input | 1 | High while the CPU is halted; a rising edge marks entry to HALT |
| clr_cmd | input | 1 | One-cycle software clear command |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | REG_W | Configuration write data |
| cfg_rdata | output | REG_W | Configuration read data; ratio select in bits 2..0 |
| to_flag | output | 1 | Time-out flag |
| pd_flag | output | 1 | Power-down flag |
| expire | output | 1 | One-cycle timeout pulse |
| expire_warm | output | 1 | Marks the pulse as a warm PC/SP reset with wake-up |

## Verification
The embedded assertions check, on every cycle, the local cause-and-effect rules:
- the timeout pulse never lasts more than one cycle;
- nothing fires in the cycle after a clear;
- a halted timeout leaves both flags set;
- a running timeout restores the maximum ratio;
- HALT entry sets the power-down flag and clears the time-out flag;
- an external reset holds both flags steady.

Only the bench scenarios can show the following:
- the exact tick count to a timeout for several ratios;
- the restart of the count after each kind of clear;
- the period of the instruction-clock variant;
- the absence of any timeout in the disabled variant.

These depend on long histories of stimulus.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Which clock advances the count chain (a build option)
    typedef enum logic {
        SRC_INSTR = 1'b0,   // system clock divided by IC_DIV
        SRC_OSC   = 1'b1    // dedicated slow oscillator tick
    } wdg_src_e;

    localparam int unsigned DIV_BITS_DEF = 8;   // fixed 256-step stage
    localparam int unsigned PRE_BITS_DEF = 7;   // programmable prescaler
    localparam int unsigned SEL_BITS_DEF = 3;   // ratio select width
    localparam int unsigned REG_W_DEF    = 8;   // config register width
    localparam int unsigned IC_DIV_DEF   = 4;   // instruction clock ratio

    // Timeout event handed from the count chain to the status logic
    typedef struct packed {
        logic fire;   // one-cycle timeout
        logic warm;   // timeout occurred while halted
    } wdg_expiry_t;

    // Number of low count bits that must be all ones for a timeout
    function automatic int unsigned tap_width(input int unsigned div_bits,
                                              input int unsigned pre_bits,
                                              input int unsigned sel);
        return div_bits + ((sel > pre_bits) ? pre_bits : sel);
    endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
    parameter wdg_pkg::wdg_src_e CLK_SEL = wdg_pkg::SRC_OSC,
    parameter int unsigned       IC_DIV  = wdg_pkg::IC_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    output logic adv
);
    localparam int unsigned PW = (IC_DIV > 1) ? $clog2(IC_DIV) : 1;

    generate
        if (CLK_SEL == wdg_pkg::SRC_OSC) begin : g_osc
            // two-stage synchroniser plus one stage for edge detection
            logic [2:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[1:0], osc_tick};
            end
            assign adv = sync_q[1] & ~sync_q[2];
        end else begin : g_instr
            logic [PW-1:0] phase_q;
            logic          unused_tick;
            assign unused_tick = osc_tick;
            always_ff @(posedge clk) begin
                if (rst)                                 phase_q <= '0;
                else if (phase_q == PW'(IC_DIV - 1))     phase_q <= '0;
                else                                     phase_q <= phase_q + PW'(1);
            end
            assign adv = (phase_q == PW'(IC_DIV - 1));
        end
    endgenerate

    // R2
    adv_single_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> !adv);

endmodule

// File: rtl/wdg_chain.sv
module wdg_chain #(
    parameter int unsigned DIV_BITS = wdg_pkg::DIV_BITS_DEF,
    parameter int unsigned PRE_BITS = wdg_pkg::PRE_BITS_DEF,
    parameter int unsigned SEL_BITS = wdg_pkg::SEL_BITS_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    adv,
    input  logic                    halted,
    input  logic [SEL_BITS-1:0]     sel,
    output wdg_pkg::wdg_expiry_t    evt
);
    localparam int unsigned CW = DIV_BITS + PRE_BITS;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] keep_mask;
    logic          at_end;
    logic          hit;

    // bits below the selected tap must all be ones at the terminal count
    always_comb begin
        keep_mask = ~({CW{1'b1}} << wdg_pkg::tap_width(DIV_BITS, PRE_BITS, 32'(sel)));
        at_end    = &(cnt_q | ~keep_mask);
        hit       = adv & at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || hit) cnt_q <= '0;
        else if (adv)            cnt_q <= cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
        end else begin
            evt.fire <= hit & ~clear;
            evt.warm <= hit & ~clear & halted;
        end
    end

    // R6
    fire_single_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> !evt.fire);

    // R6
    warm_with_fire_chk: assert property (@(posedge clk) disable iff (rst)
        evt.warm |-> evt.fire);

    // R5
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !evt.fire);

endmodule

// File: rtl/wdg_status.sv
module wdg_status #(
    parameter int unsigned REG_W    = wdg_pkg::REG_W_DEF,
    parameter int unsigned SEL_BITS = wdg_pkg::SEL_BITS_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ext_rst,
    input  logic                    halt_enter,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_data,
    input  wdg_pkg::wdg_expiry_t    evt,
    output logic [SEL_BITS-1:0]     sel,
    output logic                    to_q,
    output logic                    pd_q
);
    localparam logic [SEL_BITS-1:0] SEL_MAX = '1;

    logic unused_hi;
    assign unused_hi = ^wr_data[REG_W-1:SEL_BITS];

    // ratio select: back to maximum on every reset except a warm one
    always_ff @(posedge clk) begin
        if (rst || ext_rst || (evt.fire && !evt.warm)) sel <= SEL_MAX;
        else if (wr_en)                                sel <= wr_data[SEL_BITS-1:0];
    end

    // reset-cause flags; no register write reaches them
    always_ff @(posedge clk) begin
        if (rst) begin
            to_q <= 1'b0;
            pd_q <= 1'b0;
        end else if (evt.fire) begin
            to_q <= 1'b1;
            if (evt.warm) pd_q <= 1'b1;
        end else if (halt_enter) begin
            to_q <= 1'b0;
            pd_q <= 1'b1;
        end else if (clr) begin
            to_q <= 1'b0;
            pd_q <= 1'b0;
        end
    end

    // R8
    warm_flags_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fire && evt.warm |=> to_q && pd_q);

    // R7
    cold_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fire && !evt.warm |=> (sel == SEL_MAX) && to_q);

    // R9
    halt_flags_chk: assert property (@(posedge clk) disable iff (rst)
        halt_enter && !evt.fire |=> pd_q && !to_q);

    // R10
    ext_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ext_rst && !evt.fire && !halt_enter && !clr |=> $stable(to_q) && $stable(pd_q));

endmodule

// File: rtl/watchdog_guard.sv
module watchdog_guard #(
    parameter wdg_pkg::wdg_src_e CLK_SEL  = wdg_pkg::SRC_OSC,
    parameter bit                WDT_ON   = 1'b1,
    parameter int unsigned       DIV_BITS = wdg_pkg::DIV_BITS_DEF,
    parameter int unsigned       PRE_BITS = wdg_pkg::PRE_BITS_DEF,
    parameter int unsigned       SEL_BITS = wdg_pkg::SEL_BITS_DEF,
    parameter int unsigned       REG_W    = wdg_pkg::REG_W_DEF,
    parameter int unsigned       IC_DIV   = wdg_pkg::IC_DIV_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_rst,
    input  logic             osc_tick,
    input  logic             halt_mode,
    input  logic             clr_cmd,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             to_flag,
    output logic             pd_flag,
    output logic             expire,
    output logic             expire_warm
);
    logic                  adv_raw;
    logic                  adv_g;
    logic                  clr_g;
    logic                  halt_prev;
    logic                  halt_enter;
    logic                  chain_clear;
    logic [SEL_BITS-1:0]   sel;
    wdg_pkg::wdg_expiry_t  evt;

    always_ff @(posedge clk) begin
        if (rst) halt_prev <= 1'b0;
        else     halt_prev <= halt_mode;
    end
    assign halt_enter = halt_mode & ~halt_prev;

    wdg_tick_gen #(.CLK_SEL(CLK_SEL), .IC_DIV(IC_DIV)) u_tick (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .adv(adv_raw)
    );

    generate
        if (WDT_ON) begin : g_on
            assign adv_g = adv_raw;
            assign clr_g = clr_cmd;
        end else begin : g_off
            logic unused_off;
            assign unused_off = adv_raw ^ clr_cmd;
            assign adv_g      = 1'b0;
            assign clr_g      = 1'b0;
        end
    endgenerate

    assign chain_clear = ext_rst | clr_g | halt_enter;

    wdg_chain #(.DIV_BITS(DIV_BITS), .PRE_BITS(PRE_BITS), .SEL_BITS(SEL_BITS)) u_chain (
        .clk(clk), .rst(rst), .clear(chain_clear), .adv(adv_g),
        .halted(halt_mode), .sel(sel), .evt(evt)
    );

    wdg_status #(.REG_W(REG_W), .SEL_BITS(SEL_BITS)) u_status (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .halt_enter(halt_enter),
        .clr(clr_g), .wr_en(cfg_we), .wr_data(cfg_wdata), .evt(evt),
        .sel(sel), .to_q(to_flag), .pd_q(pd_flag)
    );

    assign cfg_rdata   = {{(REG_W-SEL_BITS){1'b0}}, sel};
    assign expire      = evt.fire;
    assign expire_warm = evt.warm;

endmodule

// File: tb/watchdog_guard_test.sv
module watchdog_guard_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst = 1'b0;
    logic       osc_tick = 1'b0;
    logic       halt_mode = 1'b0;
    logic       clr_cmd = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;

    logic [7:0] rd_a, rd_i, rd_o;
    logic       to_a, pd_a, ex_a, wm_a;
    logic       to_i, pd_i, ex_i, wm_i;
    logic       to_o, pd_o, ex_o, wm_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int n_a = 0, n_aw = 0, n_i = 0, n_iw = 0, n_o = 0;

    always #10 clk = ~clk;   // 50 MHz

    watchdog_guard uut (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .osc_tick(osc_tick),
        .halt_mode(halt_mode), .clr_cmd(clr_cmd), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .to_flag(to_a),
        .pd_flag(pd_a), .expire(ex_a), .expire_warm(wm_a)
    );

    watchdog_guard #(.CLK_SEL(wdg_pkg::SRC_INSTR)) uut_ic (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .osc_tick(osc_tick),
        .halt_mode(halt_mode), .clr_cmd(clr_cmd), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_i), .to_flag(to_i),
        .pd_flag(pd_i), .expire(ex_i), .expire_warm(wm_i)
    );

    watchdog_guard #(.WDT_ON(1'b0)) uut_off (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .osc_tick(osc_tick),
        .halt_mode(halt_mode), .clr_cmd(clr_cmd), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_o), .to_flag(to_o),
        .pd_flag(pd_o), .expire(ex_o), .expire_warm(wm_o)
    );

    // pulse monitors: one count per cycle the output is high
    always @(negedge clk) begin
        if (!rst) begin
            if (ex_a)         n_a++;
            if (ex_a && wm_a) n_aw++;
            if (ex_i)         n_i++;
            if (ex_i && wm_i) n_iw++;
            if (ex_o)         n_o++;
        end
    end

    function automatic int ticks_needed(input int ws);
        return 256 << ws;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic clr_pulse();
        @(negedge clk) clr_cmd = 1'b1;
        @(negedge clk) clr_cmd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = v; end
        @(negedge clk) cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic ext_pulse();
        @(negedge clk) ext_rst = 1'b1;
        @(negedge clk) ext_rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int base, baseo, k, ws;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 cfg", rd_a, 8'h07);
        check("R1 to", to_a, 0);
        check("R1 pd", pd_a, 0);
        check("R1 expire", ex_a, 0);

        // R4 upper bits dropped, R10 write leaves flags
        cfg_write(8'hF9);
        check("R4 readback", rd_a, 8'h01);
        check("R10 to after write", to_a, 0);
        check("R10 pd after write", pd_a, 0);

        // R2 ratio 0: exact tick count
        cfg_write(8'h00);
        clr_pulse();
        base = n_a;
        ticks(ticks_needed(0) - 1);
        check("R2 ws0 early", n_a - base, 0);
        ticks(1);
        check("R2 ws0 fire", n_a - base, 1);
        check("R6 cold not warm", n_aw, 0);
        check("R7 to set", to_a, 1);
        check("R7 cfg max", rd_a, 8'h07);

        // R2 ratio 2
        cfg_write(8'h02);
        clr_pulse();
        check("R9 clr clears to", to_a, 0);
        base = n_a;
        ticks(ticks_needed(2) - 1);
        check("R2 ws2 early", n_a - base, 0);
        ticks(1);
        check("R2 ws2 fire", n_a - base, 1);

        // R5 software clear restarts
        cfg_write(8'h00);
        clr_pulse();
        base = n_a;
        ticks(200);
        clr_pulse();
        ticks(ticks_needed(0) - 1);
        check("R5 clr restart early", n_a - base, 0);
        ticks(1);
        check("R5 clr restart fire", n_a - base, 1);

        // R5 external reset restarts, R10 keeps flags, resets cfg
        clr_pulse();
        cfg_write(8'h00);
        base = n_a;
        ticks(200);
        ticks(56);   // 256th tick after clear fires: to goes 1
        check("R2 fire before ext", n_a - base, 1);
        cfg_write(8'h00);
        ticks(200);
        ext_pulse();
        check("R10 ext keeps to", to_a, 1);
        check("R10 ext keeps pd", pd_a, 0);
        check("R10 ext cfg", rd_a, 8'h07);
        cfg_write(8'h00);
        base = n_a;
        ticks(ticks_needed(0) - 1);
        check("R5 ext restart early", n_a - base, 0);
        ticks(1);
        check("R5 ext restart fire", n_a - base, 1);

        // R9/R5 halt entry: flags and restart; R8 warm timeout
        cfg_write(8'h00);
        clr_pulse();
        base = n_a;
        ticks(200);
        @(negedge clk) halt_mode = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 halt pd", pd_a, 1);
        check("R9 halt to", to_a, 0);
        ticks(ticks_needed(0) - 1);
        check("R5 halt restart early", n_a - base, 0);
        ticks(1);
        check("R8 warm fire", n_a - base, 1);
        check("R6 warm qualifier", n_aw, 1);
        check("R8 to", to_a, 1);
        check("R8 pd", pd_a, 1);
        check("R8 cfg kept", rd_a, 8'h00);
        @(negedge clk) halt_mode = 1'b0;
        repeat (2) @(negedge clk);

        // R7 running timeout keeps pd
        base = n_a;
        ticks(ticks_needed(0));
        check("R7 cold fire", n_a - base, 1);
        check("R7 pd kept", pd_a, 1);
        check("R7 cfg back", rd_a, 8'h07);

        // R9 clear clears both; R11 disabled ignores clear
        clr_pulse();
        check("R9 clr to", to_a, 0);
        check("R9 clr pd", pd_a, 0);
        check("R11 off pd kept", pd_o, 1);

        // R3 instruction clock variant
        cfg_write(8'h00);
        clr_pulse();
        base = n_i;
        repeat (996) @(negedge clk);
        check("R3 ic early", n_i - base, 0);
        repeat (40) @(negedge clk);
        check("R3 ic fire", n_i - base, 1);
        check("R3 ic not warm", n_iw, 0);

        // R2 random ratios and partial counts
        for (int it = 0; it < 6; it++) begin
            ws = int'($urandom % 3);
            cfg_write(8'(ws));
            clr_pulse();
            k = int'($urandom % ticks_needed(ws));
            ticks(k);
            clr_pulse();
            base = n_a;
            ticks(ticks_needed(ws) - 1);
            check("R2 random early", n_a - base, 0);
            ticks(1);
            check("R2 random fire", n_a - base, 1);
            check("R7 random cfg", rd_a, 8'h07);
        end

        // R11 disabled variant never fired
        baseo = n_o;
        check("R11 off no expire", baseo, 0);

        finish_run();
    end

endmodule